// File: doc/BRIEF.md
# Ready-Stall Timeout Monitor

This block sits beside the bridge between a host bus and a slow peripheral bus. While a peripheral-bus cycle is in progress, it watches the peripheral's ready line. As long as the peripheral holds ready low, the monitor asks the host side to stay in its extended wait state. An 8-bit control byte can enable a stall limit. When ready stays low for longer than that limit, the monitor drops the wait request even though ready is still low. It also raises a one-clock timeout flag, so the host transaction can finish instead of hanging.

The control byte holds an enable bit and a limit field, and it can be written and read back at any time. A stall counter advances on every peripheral-bus clock in which a cycle is active and ready is low. Any high sample of ready clears the counter, and so does any clock without an active cycle. A timeout therefore needs one unbroken low-ready interval inside one cycle. Everything runs on the single peripheral-bus clock. Ready is taken to be synchronous to that clock already.

Top module: `stall_timeout_mon`

## Requirements
- R1: After reset the control readback is 0x63 (enable off, limit 99), and both hostWait and timeoutPulse are low.
- R2: A byte presented with cfgWrEn high is stored at that clock edge and appears on cfgRdData from the next clock on.
- R3: While cycActive is high and periphReady is low, hostWait is high from the clock after the first low sample. hostWait goes low in the clock after periphReady is sampled high.
- R4: When bit 7 of the control byte is 1 and bits 6..0 hold the limit L, timeoutPulse is high in the clock after the (L+1)-th consecutive active low-ready sample. hostWait goes low in that same clock.
- R5: When bit 7 of the control byte is 0, timeoutPulse never rises, and hostWait stays high for as long as the stall lasts.
- R6: A high sample of periphReady during a cycle restarts the stall count, so only an unbroken run of L+1 low samples fires the timeout.
- R7: timeoutPulse lasts exactly one clock. After it, hostWait and timeoutPulse stay low until cycActive is sampled low. A later stall then times out again.
- R8: With the enable bit set and a limit of 0, the timeout fires after one low-ready sample, and hostWait is never raised for that stall.
- R9: A control write during a stall governs the decision at the next clock edge. If the new limit is at or below the number of low samples already counted, the timeout fires at that edge.
- R10: While cycActive is low, hostWait and timeoutPulse are low in the following clock whatever periphReady does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral-bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control byte write strobe |
| cfgWrData | input | 8 | Control byte write data: bit 7 enable, bits 6..0 limit |
| cfgRdData | output | 8 | Control byte readback |
| cycActive | input | 1 | A peripheral-bus cycle is in progress |
| periphReady | input | 1 | Peripheral ready line, synchronous |
| hostWait | output | 1 | Request to keep the host side in its extended wait |
| timeoutPulse | output | 1 | One-clock flag marking a forced end of a stall |

## Verification
A stall counter that is off by one shows up directly at the ports: timeoutPulse appears one clock early or late relative to the (L+1)-th low sample, and hostWait drops at that same wrong clock. The limits used are small, so such an error shows within a few clocks. A lost expired flag lets timeoutPulse repeat, or lets hostWait rise again during the same cycle, in the clock right after the pulse. A counter that is not cleared on a ready-high sample makes an interrupted stall fire early. A control byte that is captured late or with the wrong width shows on readback one clock after the write. It also shows as a timeout that is missing or mistimed in the mid-stall limit change.

// File: rtl/stm_pkg.sv
package stm_pkg;

  // Strobes from the control module to the datapath counter
  typedef struct packed {
    logic cntClr;   // restart the low-ready count
    logic cntInc;   // one more low-ready sample seen
  } stallStrobe_t;

  // Control module state, reported for the bound checker
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STALL   = 2'd1,
    ST_EXPIRED = 2'd2
  } stallState_t;

endpackage

// File: rtl/stm_datapath.sv
module stm_datapath
  import stm_pkg::*;
#(
  parameter int unsigned LIMIT_W = 7,
  parameter int unsigned RST_CFG = 'h63
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [LIMIT_W:0]   cfgWrData,
  input  stallStrobe_t       strobe,
  output logic [LIMIT_W:0]   cfgQ,
  output logic               tmoEn,
  output logic               limitReached
);

  localparam int unsigned CFG_W = LIMIT_W + 1;
  localparam logic [LIMIT_W-1:0] CNT_MAX = {LIMIT_W{1'b1}};

  logic [CFG_W-1:0]   cfgReg;
  logic [LIMIT_W-1:0] stallCnt;
  logic [LIMIT_W-1:0] limitVal;

  // Control byte: top bit enables, low bits hold the limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= CFG_W'(RST_CFG);
    end else if (cfgWrEn) begin
      cfgReg <= cfgWrData;
    end
  end

  assign limitVal = cfgReg[LIMIT_W-1:0];
  assign tmoEn    = cfgReg[LIMIT_W];
  assign cfgQ     = cfgReg;

  // Low-ready sample counter, saturating so a long disabled stall cannot wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0;
    end else if (strobe.cntClr) begin
      stallCnt <= '0;
    end else if (strobe.cntInc && (stallCnt != CNT_MAX)) begin
      stallCnt <= stallCnt + 1'b1;
    end
  end

  // stallCnt holds the low samples before this clock; this clock is one more
  assign limitReached = (stallCnt >= limitVal);

endmodule

// File: rtl/stm_control.sv
module stm_control
  import stm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cycActive,
  input  logic         periphReady,
  input  logic         tmoEn,
  input  logic         limitReached,
  output stallStrobe_t strobe,
  output logic         hostWait,
  output logic         timeoutPulse,
  output stallState_t  stateQ
);

  stallState_t state;
  stallState_t stateNext;
  logic        stallNow;
  logic        expired;
  logic        fireNow;
  logic        waitNext;

  assign stallNow = cycActive && !periphReady;
  assign expired  = (state == ST_EXPIRED);
  assign fireNow  = stallNow && tmoEn && !expired && limitReached;
  assign waitNext = stallNow && !expired && !fireNow;

  always_comb begin
    strobe.cntClr = !stallNow;
    strobe.cntInc = stallNow && !expired;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (fireNow)       stateNext = ST_EXPIRED;
        else if (stallNow) stateNext = ST_STALL;
      end
      ST_STALL: begin
        if (fireNow)        stateNext = ST_EXPIRED;
        else if (!stallNow) stateNext = ST_IDLE;
      end
      ST_EXPIRED: begin
        if (!cycActive) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      hostWait     <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      state        <= stateNext;
      hostWait     <= waitNext;
      timeoutPulse <= fireNow;
    end
  end

  assign stateQ = state;

endmodule

// File: rtl/stall_timeout_mon.sv
module stall_timeout_mon
  import stm_pkg::*;
#(
  parameter int unsigned LIMIT_W = 7,
  parameter int unsigned RST_CFG = 'h63
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [LIMIT_W:0] cfgWrData,
  output logic [LIMIT_W:0] cfgRdData,
  input  logic             cycActive,
  input  logic             periphReady,
  output logic             hostWait,
  output logic             timeoutPulse
);

  stallStrobe_t strobe;
  stallState_t  ctlState;
  logic         tmoEn;
  logic         limitReached;

  stm_datapath #(
    .LIMIT_W (LIMIT_W),
    .RST_CFG (RST_CFG)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (cfgWrData),
    .strobe       (strobe),
    .cfgQ         (cfgRdData),
    .tmoEn        (tmoEn),
    .limitReached (limitReached)
  );

  stm_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .cycActive    (cycActive),
    .periphReady  (periphReady),
    .tmoEn        (tmoEn),
    .limitReached (limitReached),
    .strobe       (strobe),
    .hostWait     (hostWait),
    .timeoutPulse (timeoutPulse),
    .stateQ       (ctlState)
  );

endmodule

// File: rtl/stm_checker.sv
module stm_checker
  import stm_pkg::*;
#(
  parameter int unsigned LIMIT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [LIMIT_W:0] cfgWrData,
  input logic [LIMIT_W:0] cfgRdData,
  input logic             cycActive,
  input logic             periphReady,
  input logic             hostWait,
  input logic             timeoutPulse,
  input stallState_t      ctlState
);

  // R2: a written byte is read back on the next clock
  p_write_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgRdData == $past(cfgWrData)));

  // R3: a ready-high sample releases the wait on the next clock
  p_wait_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cycActive && periphReady) |=> !hostWait);

  // R4: the timeout flag and the wait request never overlap
  p_pulse_drops_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> !hostWait);

  // R5: with the enable bit clear no timeout follows
  p_no_pulse_disabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdData[LIMIT_W] |=> !timeoutPulse);

  // R7: the flag is one clock wide and the wait stays released
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  p_expired_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutPulse && cycActive) |=> (!hostWait && ctlState == ST_EXPIRED));

  // R10: an idle bus gives no wait and no flag
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cycActive |=> (!hostWait && !timeoutPulse));

endmodule

bind stall_timeout_mon stm_checker #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgWrEn      (cfgWrEn),
  .cfgWrData    (cfgWrData),
  .cfgRdData    (cfgRdData),
  .cycActive    (cycActive),
  .periphReady  (periphReady),
  .hostWait     (hostWait),
  .timeoutPulse (timeoutPulse),
  .ctlState     (ctlState)
);

// File: tb/test_stall_timeout_mon.sv
`timescale 1ns/1ps
module test_stall_timeout_mon;

  typedef struct {
    logic       expWait;
    logic       expPulse;
    logic [7:0] expRd;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic       cycActive = 1'b0;
  logic       periphReady = 1'b1;
  logic       hostWait;
  logic       timeoutPulse;

  int         nVec = 0;
  int         nBad = 0;
  logic [7:0] cfgShadow = 8'h63;
  bit         done = 1'b0;
  expItem_t   expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  stall_timeout_mon i_stall_timeout_mon (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (cfgWrData),
    .cfgRdData    (cfgRdData),
    .cycActive    (cycActive),
    .periphReady  (periphReady),
    .hostWait     (hostWait),
    .timeoutPulse (timeoutPulse)
  );

  task automatic compare(input expItem_t e);
    nVec++;
    if (hostWait !== e.expWait || timeoutPulse !== e.expPulse || cfgRdData !== e.expRd) begin
      nBad++;
      $display("FAIL %s: wait=%0b pulse=%0b rd=%02h expected wait=%0b pulse=%0b rd=%02h",
               e.tag, hostWait, timeoutPulse, cfgRdData, e.expWait, e.expPulse, e.expRd);
    end
  endtask

  // Driver: apply one clock of stimulus and queue the outputs expected after its edge
  task automatic step(input logic act, input logic rdy, input logic wr, input logic [7:0] wd,
                      input logic eW, input logic eP, input string tag);
    expItem_t e;
    @(negedge clk);
    cycActive   = act;
    periphReady = rdy;
    cfgWrEn     = wr;
    cfgWrData   = wd;
    if (wr) cfgShadow = wd;
    e.expWait  = eW;
    e.expPulse = eP;
    e.expRd    = cfgShadow;
    e.tag      = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compare shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    expItem_t r;
    repeat (3) @(negedge clk);
    r.expWait = 1'b0; r.expPulse = 1'b0; r.expRd = 8'h63; r.tag = "R1 reset state";
    compare(r);
    rstN = 1'b1;

    // R5 / R3: default disabled, long stall keeps waiting
    for (int k = 1; k <= 120; k++) step(1, 0, 0, 8'h00, 1, 0, "R5 disabled stall");
    step(1, 1, 0, 8'h00, 0, 0, "R3 release on ready");
    step(0, 1, 0, 8'h00, 0, 0, "R10 idle");

    // R2: enable, limit 5
    step(0, 0, 1, 8'h85, 0, 0, "R2 write readback");
    step(0, 0, 0, 8'h00, 0, 0, "R10 idle ready low");

    // R4 / R7: L=5, pulse after 6th low sample
    for (int k = 1; k <= 5; k++) step(1, 0, 0, 8'h00, 1, 0, "R4 waiting");
    step(1, 0, 0, 8'h00, 0, 1, "R4 timeout fires");
    for (int k = 1; k <= 4; k++) step(1, 0, 0, 8'h00, 0, 0, "R7 stays expired");
    step(1, 1, 0, 8'h00, 0, 0, "R7 ready after expiry");
    step(1, 0, 0, 8'h00, 0, 0, "R7 no rearm in same cycle");
    step(0, 0, 0, 8'h00, 0, 0, "R10 cycle ends");

    // R6: interrupted stall restarts the count
    for (int k = 1; k <= 5; k++) step(1, 0, 0, 8'h00, 1, 0, "R6 first run");
    step(1, 1, 0, 8'h00, 0, 0, "R6 ready blip");
    for (int k = 1; k <= 5; k++) step(1, 0, 0, 8'h00, 1, 0, "R6 second run");
    step(1, 0, 0, 8'h00, 0, 1, "R6 fires after full run");
    step(0, 1, 0, 8'h00, 0, 0, "R10 cycle ends");

    // R7: new cycle times out again
    for (int k = 1; k <= 5; k++) step(1, 0, 0, 8'h00, 1, 0, "R7 rearmed wait");
    step(1, 0, 0, 8'h00, 0, 1, "R7 rearmed fire");
    step(0, 1, 0, 8'h00, 0, 0, "R10 cycle ends");

    // R8: limit 0
    step(0, 1, 1, 8'h80, 0, 0, "R2 write limit zero");
    step(1, 0, 0, 8'h00, 0, 1, "R8 fires after one sample");
    step(1, 0, 0, 8'h00, 0, 0, "R8 no wait afterwards");
    step(0, 1, 0, 8'h00, 0, 0, "R10 cycle ends");

    // R9: lowering the limit mid-stall
    step(0, 1, 1, 8'h94, 0, 0, "R2 write limit 20");
    for (int k = 1; k <= 10; k++) step(1, 0, 0, 8'h00, 1, 0, "R9 stall before write");
    step(1, 0, 1, 8'h83, 1, 0, "R9 write lands");
    step(1, 0, 0, 8'h00, 0, 1, "R9 fires at once");
    step(0, 0, 0, 8'h00, 0, 0, "R10 idle after fire");

    // R5: disable again, stall past old limit
    step(0, 1, 1, 8'h03, 0, 0, "R2 write disabled");
    for (int k = 1; k <= 10; k++) step(1, 0, 0, 8'h00, 1, 0, "R5 disabled no timeout");
    step(0, 0, 0, 8'h00, 0, 0, "R10 idle");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule